// File: doc/BRIEF.md
# Masked Interrupt Controller with Sleep Wakeup

This block collects interrupt events for a small 8-bit processor core and decides when the fetch unit must be redirected. It has three hardware sources: an asynchronous external pin with a programmable active edge, a one-cycle timer overflow strobe, and a detector that compares an 8-bit input port against a snapshot taken on the last port read. Each source has a sticky flag and an individual enable. A global enable sits in the top bit of the enable register. Software reaches both registers through a small register bus with a select line.

A sequencer built around one enumerated state register handles redirection. In `ST_RUN` a software-interrupt strobe moves to `ST_SW_VEC` and issues the software vector (0x002). Otherwise, a masked pending flag with the global enable set moves to `ST_HW_VEC`: the hardware vector (0x008) is issued and the global enable is cleared. Otherwise, a sleep request moves to `ST_SLEEP`. In `ST_SLEEP` only a latched and enabled external-pin flag leaves the state. With the global enable set it goes to `ST_WAKE_VEC`, which raises wake and issues the hardware vector and clears the global enable. Without it, it goes to `ST_WAKE_RESUME`, which raises wake only, so the core continues with the next instruction. `ST_HW_VEC`, `ST_SW_VEC`, `ST_WAKE_VEC` and `ST_WAKE_RESUME` each last one cycle and always return to `ST_RUN`. A return-from-interrupt strobe sets the global enable again.

Top module: `evt_irq_ctl`

## Requirements
- R1: After reset both registers read 0x00, and `take_irq` and `wake` are low.
- R2: With `ext_rise`=1 a rising edge on `ext_pin` sets flag bit 2, and with `ext_rise`=0 a falling edge sets it. The opposite edge sets nothing. The flag is visible on the third rising clock edge after the pin changes, counting two synchronizer stages and one edge-detect stage.
- R3: A `tmr_ovf` strobe sets flag bit 0 at the next clock edge, whether or not enable bit 0 is set.
- R4: When `port_in` differs from the snapshot, flag bit 1 sets only while enable bit 1 is set. A cycle with `port_rd` high loads the snapshot from `port_in` and sets no flag.
- R5: A read with `reg_sel`=0 returns the flags ANDed with enable bits 2:0, with bits 7:3 zero. A read with `reg_sel`=1 returns the enable register, which keeps only bits 7, 2, 1 and 0.
- R6: In `ST_RUN`, when the global enable (bit 7) is set and some flag is set together with its enable, `take_irq` is high for exactly one cycle with `vec_addr`=0x008 on the following edge, and the global enable reads 0 from then on.
- R7: No hardware vector is issued while the global enable is clear or while every set flag has its enable clear.
- R8: A `swi` strobe gives `take_irq` with `vec_addr`=0x002 in the next cycle and leaves the global enable unchanged. It takes priority over a hardware interrupt in the same cycle, and that interrupt follows once the sequencer is back in `ST_RUN`.
- R9: `reti` sets the global enable. Flags stay set until a register write with `reg_sel`=0 changes them.
- R10: In `ST_SLEEP`, a latched and enabled external-pin flag raises `wake` for one cycle. If the global enable is set, `take_irq` with 0x008 comes in the same cycle. If it is clear, `take_irq` stays low. Timer and port flags never wake.
- R11: When an event and a register write clearing its flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ext_rise | input | 1 | 1 = rising edge active, 0 = falling edge active |
| tmr_ovf | input | 1 | Timer overflow strobe |
| port_in | input | 8 | Watched input port value |
| port_rd | input | 1 | Port read strobe, loads the snapshot |
| reg_sel | input | 1 | 0 = flag register, 1 = enable register |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| swi | input | 1 | Software interrupt instruction strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| sleep_req | input | 1 | Sleep instruction strobe |
| vec_addr | output | 11 | Vector address, valid while take_irq is high |
| take_irq | output | 1 | Redirect the next fetch to vec_addr |
| wake | output | 1 | Leave sleep |

## Verification
The bench checks the exact cycle at which an external edge becomes a flag. A design with a missing or extra synchronizer stage shows the flag one edge early or late. The bench also checks that a wrong-polarity edge leaves the flag clear. It uses a port mismatch raised while its enable is off, removed, and then followed by the enable, to show the port flag never latched. A design that sets that flag without the enable reads 1 at that point. It drives `swi` together with a timer interrupt and expects the 0x002 vector, then a gap, then 0x008; wrong priority or a lost hardware request changes that order. In sleep it checks that a timer flag does not wake the core and that the external wake issues a vector only when the global enable is set.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int FLAG_TMR  = 0;
    localparam int FLAG_PORT = 1;
    localparam int FLAG_EXT  = 2;
    localparam int NUM_SRC   = 3;
    localparam int GIE_BIT   = 7;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_HW_VEC,
        ST_SW_VEC,
        ST_WAKE_VEC,
        ST_WAKE_RESUME
    } seq_state_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic rise_sel,
    output logic edge_hit
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              pin_sync;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign pin_sync = chain_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_sync;
    end

    always_comb begin
        if (rise_sel) edge_hit = pin_sync & ~prev_q;
        else          edge_hit = ~pin_sync & prev_q;
    end
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] port_in,
    input  logic             snap_load,
    output logic             change_hit
);
    logic [WIDTH-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         snap_q <= '0;
        else if (snap_load) snap_q <= port_in;
    end

    // a read cycle refreshes the snapshot and reports nothing
    assign change_hit = (|(port_in ^ snap_q)) & ~snap_load;
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs #(
    parameter int                 NSRC      = 3,
    parameter int                 DW        = 8,
    parameter int                 GIE_POS   = 7,
    parameter logic [DW-1:0]      EN_KEEP   = 8'h87,
    parameter logic [NSRC-1:0]    GATED     = 3'b010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            wr_flags,
    input  logic            wr_en,
    input  logic [DW-1:0]   wdata,
    input  logic            set_gie,
    input  logic            clr_gie,
    output logic [NSRC-1:0] flags_q,
    output logic [DW-1:0]   en_q
);
    logic [NSRC-1:0] flags_d;
    logic [DW-1:0]   en_d;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_flag
            logic hit;
            if (GATED[g]) begin : g_gated
                assign hit = evt[g] & en_q[g];
            end else begin : g_free
                assign hit = evt[g];
            end
            // an event beats a software write in the same cycle
            assign flags_d[g] = hit ? 1'b1 : (wr_flags ? wdata[g] : flags_q[g]);
        end
    endgenerate

    always_comb begin
        en_d = wr_en ? (wdata & EN_KEEP) : en_q;
        if (set_gie) en_d[GIE_POS] = 1'b1;
        if (clr_gie) en_d[GIE_POS] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            en_q    <= '0;
        end else begin
            flags_q <= flags_d;
            en_q    <= en_d;
        end
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic gie,
    input  logic wake_src,
    input  logic swi,
    input  logic sleep_req,
    output logic take_irq,
    output logic vec_hw,
    output logic wake,
    output logic clr_gie
);
    seq_state_t state_q;
    seq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (swi)                 state_d = ST_SW_VEC;
                else if (gie && pending) state_d = ST_HW_VEC;
                else if (sleep_req)      state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_src) state_d = gie ? ST_WAKE_VEC : ST_WAKE_RESUME;
            end
            ST_HW_VEC, ST_SW_VEC, ST_WAKE_VEC, ST_WAKE_RESUME: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        take_irq = 1'b0;
        vec_hw   = 1'b0;
        wake     = 1'b0;
        unique case (state_q)
            ST_HW_VEC:      begin take_irq = 1'b1; vec_hw = 1'b1; end
            ST_SW_VEC:      begin take_irq = 1'b1; end
            ST_WAKE_VEC:    begin take_irq = 1'b1; vec_hw = 1'b1; wake = 1'b1; end
            ST_WAKE_RESUME: begin wake = 1'b1; end
            ST_RUN, ST_SLEEP: ;
            default: ;
        endcase
        clr_gie = (state_d == ST_HW_VEC) || (state_d == ST_WAKE_VEC);
    end
endmodule

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2,
    parameter int HW_VEC_ADDR = 8,
    parameter int SW_VEC_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              ext_rise,
    input  logic              tmr_ovf,
    input  logic [PORT_W-1:0] port_in,
    input  logic              port_rd,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              swi,
    input  logic              reti,
    input  logic              sleep_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              take_irq,
    output logic              wake
);
    localparam logic [DATA_W-1:0] EN_KEEP = DATA_W'((1 << GIE_BIT) | ((1 << NUM_SRC) - 1));
    localparam logic [NUM_SRC-1:0] GATED  = NUM_SRC'(1 << FLAG_PORT);

    logic               ext_hit;
    logic               port_hit;
    logic [NUM_SRC-1:0] evt;
    logic [NUM_SRC-1:0] flags_q;
    logic [DATA_W-1:0]  en_q;
    logic [NUM_SRC-1:0] masked;
    logic               gie_q;
    logic               clr_gie;
    logic               vec_hw;

    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
        .clk(clk), .rst_n(rst_n), .pin_async(ext_pin),
        .rise_sel(ext_rise), .edge_hit(ext_hit)
    );

    irq_port_watch #(.WIDTH(PORT_W)) u_port (
        .clk(clk), .rst_n(rst_n), .port_in(port_in),
        .snap_load(port_rd), .change_hit(port_hit)
    );

    always_comb begin
        evt            = '0;
        evt[FLAG_TMR]  = tmr_ovf;
        evt[FLAG_PORT] = port_hit;
        evt[FLAG_EXT]  = ext_hit;
    end

    irq_flag_regs #(
        .NSRC(NUM_SRC), .DW(DATA_W), .GIE_POS(GIE_BIT),
        .EN_KEEP(EN_KEEP), .GATED(GATED)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .wr_flags(reg_wr && !reg_sel), .wr_en(reg_wr && reg_sel),
        .wdata(reg_wdata), .set_gie(reti), .clr_gie(clr_gie),
        .flags_q(flags_q), .en_q(en_q)
    );

    assign masked = flags_q & en_q[NUM_SRC-1:0];
    assign gie_q  = en_q[GIE_BIT];

    irq_seq u_seq (
        .clk(clk), .rst_n(rst_n), .pending(|masked), .gie(gie_q),
        .wake_src(masked[FLAG_EXT]), .swi(swi), .sleep_req(sleep_req),
        .take_irq(take_irq), .vec_hw(vec_hw), .wake(wake), .clr_gie(clr_gie)
    );

    always_comb begin
        if (!take_irq)   vec_addr = '0;
        else if (vec_hw) vec_addr = ADDR_W'(HW_VEC_ADDR);
        else             vec_addr = ADDR_W'(SW_VEC_ADDR);
    end

    assign reg_rdata = reg_sel ? en_q : {{(DATA_W-NUM_SRC){1'b0}}, masked};
endmodule

// File: rtl/evt_irq_ctl_chk.sv
module evt_irq_ctl_chk #(
    parameter int ADDR_W      = 11,
    parameter int NSRC        = 3,
    parameter int HW_VEC_ADDR = 8,
    parameter int SW_VEC_ADDR = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              take_irq,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              wake,
    input logic              reti,
    input logic              tmr_ovf,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic              gie,
    input logic [NSRC-1:0]   flags
);
    localparam logic [ADDR_W-1:0] HWV = ADDR_W'(HW_VEC_ADDR);
    localparam logic [ADDR_W-1:0] SWV = ADDR_W'(SW_VEC_ADDR);

    p_take_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq);
    p_vec_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (vec_addr == HWV || vec_addr == SWV));
    p_hw_clears_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && vec_addr == HWV) |-> !gie);
    p_no_hw_without_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> !(take_irq && vec_addr == HWV));
    p_reti_sets_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !gie) |=> gie);
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !(reg_wr && !reg_sel)) |=> flags[0]);
    p_timer_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> flags[0]);
    p_wake_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);
endmodule

bind evt_irq_ctl evt_irq_ctl_chk #(
    .ADDR_W(ADDR_W), .NSRC(3), .HW_VEC_ADDR(HW_VEC_ADDR), .SW_VEC_ADDR(SW_VEC_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .take_irq(take_irq), .vec_addr(vec_addr),
    .wake(wake), .reti(reti), .tmr_ovf(tmr_ovf), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .gie(gie_q), .flags(flags_q)
);

// File: tb/evt_irq_ctl_test.sv
module evt_irq_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin = 1'b0, ext_rise = 1'b1, tmr_ovf = 1'b0;
    logic [7:0]  port_in = 8'h00;
    logic        port_rd = 1'b0, reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        swi = 1'b0, reti = 1'b0, sleep_req = 1'b0;
    logic [10:0] vec_addr;
    logic        take_irq, wake;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evt_irq_ctl uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_rise(ext_rise),
        .tmr_ovf(tmr_ovf), .port_in(port_in), .port_rd(port_rd),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .swi(swi), .reti(reti), .sleep_req(sleep_req),
        .vec_addr(vec_addr), .take_irq(take_irq), .wake(wake)
    );

    function automatic logic [7:0] exp_flag_read(logic [2:0] fl, logic [7:0] en);
        return {5'b0, fl & en[2:0]};
    endfunction

    function automatic logic [7:0] exp_en_write(logic [7:0] d);
        return d & 8'h87;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic chk_take(string tag, logic t, logic [10:0] v);
        check({tag, " take_irq"}, 32'(take_irq), 32'(t));
        if (t) check({tag, " vec_addr"}, 32'(vec_addr), 32'(v));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [2:0] fm;
        logic [7:0] em;
        void'($urandom(32'h1ACE));
        step(3);
        rst_n = 1'b1;
        step();

        // R1 reset state
        rd(0, v); check("R1 flags", 32'(v), 32'h00);
        rd(1, v); check("R1 enables", 32'(v), 32'h00);
        check("R1 take", 32'(take_irq), 0);
        check("R1 wake", 32'(wake), 0);

        // R3 timer flag latches while masked
        tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0;
        wr(1, 8'h01);
        rd(0, v); check("R3 timer masked", 32'(v), 32'h01);
        wr(0, 8'h00);
        rd(0, v); check("R9 write clears", 32'(v), 32'h00);

        // R11 event beats clearing write
        tmr_ovf = 1'b1; wr(0, 8'h00); tmr_ovf = 1'b0;
        rd(0, v); check("R11 set wins", 32'(v), 32'h01);
        wr(0, 8'h00);

        // R5 enable register keeps only bits 7,2:0
        wr(1, 8'hFF);
        rd(1, v); check("R5 enable mask", 32'(v), 32'h87);
        wr(1, 8'h05);
        rd(1, v); check("R5 enable value", 32'(v), 32'h05);

        // R2 external edge timing and polarity
        ext_rise = 1'b1; ext_pin = 1'b1;
        step(2); rd(0, v); check("R2 not yet", 32'(v), 32'h00);
        step();  rd(0, v); check("R2 rising flag", 32'(v), 32'h04);
        wr(0, 8'h00);
        ext_pin = 1'b0; step(4);
        rd(0, v); check("R2 falling ignored", 32'(v), 32'h00);
        ext_rise = 1'b0; ext_pin = 1'b1; step(4);
        rd(0, v); check("R2 rising ignored", 32'(v), 32'h00);
        ext_pin = 1'b0; step(3);
        rd(0, v); check("R2 falling flag", 32'(v), 32'h04);
        wr(0, 8'h00); ext_rise = 1'b1;

        // R4 port change gated by its enable
        wr(1, 8'h00);
        port_rd = 1'b1; step(); port_rd = 1'b0;
        port_in = 8'h10; step(2); port_in = 8'h00;
        wr(1, 8'h02);
        rd(0, v); check("R4 gated off", 32'(v), 32'h00);
        port_in = 8'h01; step();
        rd(0, v); check("R4 change flag", 32'(v), 32'h02);
        port_in = 8'h55; wr(0, 8'h00);
        port_rd = 1'b1; step(); port_rd = 1'b0;
        wr(0, 8'h00); step();
        rd(0, v); check("R4 snapshot reload", 32'(v), 32'h00);

        // R6 hardware interrupt entry
        wr(1, 8'h81);
        tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0;
        chk_take("R6 not yet", 1'b0, 11'h0);
        step(); chk_take("R6 entry", 1'b1, 11'h008);
        rd(1, v); check("R6 gie cleared", 32'(v), 32'h01);
        step(); chk_take("R6 one cycle", 1'b0, 11'h0);

        // R7 / R9 flag stays, no entry with gie clear; reti re-enables
        step(3); chk_take("R7 gie clear", 1'b0, 11'h0);
        rd(0, v); check("R9 flag sticky", 32'(v), 32'h01);
        reti = 1'b1; step(); reti = 1'b0;
        rd(1, v); check("R9 reti sets gie", 32'(v), 32'h81);
        step(); chk_take("R9 pending taken", 1'b1, 11'h008);
        wr(0, 8'h00);
        wr(1, 8'h80);
        tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0; step(2);
        chk_take("R7 source masked", 1'b0, 11'h0);
        wr(0, 8'h00);

        // R8 software interrupt priority
        wr(1, 8'h81);
        swi = 1'b1; tmr_ovf = 1'b1; step(); swi = 1'b0; tmr_ovf = 1'b0;
        chk_take("R8 swi vector", 1'b1, 11'h002);
        rd(1, v); check("R8 gie kept", 32'(v), 32'h81);
        step(); chk_take("R8 gap", 1'b0, 11'h0);
        step(); chk_take("R8 hw follows", 1'b1, 11'h008);
        wr(0, 8'h00);

        // R10 sleep with gie set: timer does not wake, pin does
        wr(1, 8'h85);
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
        tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0; step(2);
        check("R10 timer no wake", 32'(wake), 0);
        chk_take("R10 timer no take", 1'b0, 11'h0);
        ext_pin = 1'b1; step(3);
        check("R10 not yet", 32'(wake), 0);
        step();
        check("R10 wake", 32'(wake), 1);
        chk_take("R10 wake vector", 1'b1, 11'h008);
        step(); check("R10 wake pulse", 32'(wake), 0);
        rd(1, v); check("R10 gie cleared", 32'(v), 32'h05);
        ext_pin = 1'b0; step(3); wr(0, 8'h00);

        // R10 sleep with gie clear resumes without vector
        wr(1, 8'h04);
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
        ext_pin = 1'b1; step(4);
        check("R10 resume wake", 32'(wake), 1);
        chk_take("R10 resume no take", 1'b0, 11'h0);
        ext_pin = 1'b0; step(3); wr(0, 8'h00);

        // R3 R5 R11 random register traffic with gie held clear
        fm = 3'b000; em = 8'h04;
        for (int it = 0; it < 300; it++) begin
            logic t, w;
            logic [7:0] d;
            t = 1'($urandom);
            w = 1'($urandom);
            d = 8'($urandom) & 8'h7F;
            reg_sel = 1'($urandom);
            reg_wdata = d; reg_wr = w; tmr_ovf = t;
            if (w && !reg_sel) fm = d[2:0];
            if (w && reg_sel) em = exp_en_write(d);
            if (t) fm[0] = 1'b1;
            step();
            reg_wr = 1'b0; tmr_ovf = 1'b0;
            rd(0, v); check("R5 random flag read", 32'(v), 32'(exp_flag_read(fm, em)));
            rd(1, v); check("R5 random enable read", 32'(v), 32'(em));
        end
        chk_take("R7 random no entry", 1'b0, 11'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule